// File: doc/BRIEF.md
# Low-Speed USB Line Receiver

This block turns the raw D+/D- levels of a low-speed USB link into a stream of bytes. The system clock runs at eight times the bit rate, so every bit occupies a fixed number of clock cycles. While the bus is quiet the receiver waits for the idle (J) state. It then watches for the first J-to-K edge, which sets its sampling phase close to the middle of each bit. It only accepts that edge as the end of the sync field when the bit after the sampled K is also a K. Once locked, it samples each bit once, decodes the NRZI line code and drops the stuffed bits. It packs the data bits into bytes, least significant bit first.

Each completed byte goes out on a valid/ready port. The receiver cannot slow the line down, so back-pressure is limited. A byte stays on the port until the sink accepts it or until the next byte completes. The next byte takes at least one byte time (64 clocks by default) to arrive. If the sink has not accepted the old byte by then, the new byte replaces it. A sink that accepts in the same cycle that the next byte lands takes the old byte, and the new byte shows as valid from the next cycle.

A single-ended zero (SE0) seen at a sample point ends the packet, unless it falls in the first bit slot of a byte. The receiver then gives a one-cycle packet-end pulse carrying the number of whole bytes received. A packet longer than the byte budget is abandoned and the overflow pulse is given instead. After either outcome the receiver waits for idle again.

Top module: `usbrx_ls_rx`

## Requirements
- R1: Each bit lasts OVS clocks and is sampled once. A data bit is 1 when the sampled line level (D-) matches the previous sample and 0 when it differs. The first data bit is compared against the final K of sync. Bytes are assembled least significant bit first.
- R2: After reset, and after every packet, the receiver must first see J (dp=0, dm=1) before it hunts for a K (dp=1, dm=0). It locks only when a K edge is followed by K at the centre of the next bit. A J there sends it back to hunting, and a line that has never been J produces no bytes.
- R3: The bit that follows six consecutive decoded 1s is a stuffed bit. It is discarded and not counted as data.
- R4: out_valid with out_data stays asserted until a cycle with out_ready high. A byte that completes while an older byte is still unaccepted replaces it. If acceptance and a new byte fall in the same cycle, the old byte is taken and the new byte is valid on the next cycle.
- R5: SE0 (dp=0, dm=0) at a sample point in bit slot 1 to 7 ends the packet. pkt_end pulses for one cycle, pkt_bytes gives the number of complete bytes received, and bits of a partial byte are dropped.
- R6: SE0 at the sample point of bit slot 0 of a byte (the first bit position after a completed byte, stuffed bits included) does not end the packet. It is decoded as a K level.
- R7: When byte number BUF_BYTES+1 completes, it is not delivered. overflow pulses for one cycle, no pkt_end is given for that packet, and the receiver waits for J again.
- R8: During and right after reset, out_valid, pkt_end and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OVS times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| dp | input | 1 | Synchronised D+ sample |
| dm | input | 1 | Synchronised D- sample |
| out_valid | output | 1 | A received byte is on out_data |
| out_ready | input | 1 | Sink accepts the byte this cycle |
| out_data | output | 8 | Received byte |
| pkt_end | output | 1 | One-cycle pulse at end of packet |
| pkt_bytes | output | CNT_W | Complete bytes in the finished packet, valid with pkt_end |
| overflow | output | 1 | One-cycle pulse when the packet exceeds BUF_BYTES |

## Verification
The two functions that can meet in one clock edge are the sink's acceptance of a held byte and the arrival of the next decoded byte. To provoke this, a packet of zero bytes is sent, which has no stuffing, so each byte lands exactly 64 clocks after the previous one. out_ready is held low after the first byte appears and is raised for just the cycle in which the next byte lands. The test passes if the stream seen through the handshake holds every byte once, in order, with none lost to replacement. A separate test keeps out_ready low for a whole packet and expects only the last byte to remain on the port.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    HS_WAIT_IDLE,
    HS_HUNT_EDGE,
    HS_CONFIRM
  } hunt_state_t;

  function automatic logic line_is_j(input logic p, input logic m);
    return !p && m;
  endfunction

  function automatic logic line_is_k(input logic p, input logic m);
    return p && !m;
  endfunction

  function automatic logic line_is_se0(input logic p, input logic m);
    return !p && !m;
  endfunction
endpackage

// File: rtl/usbrx_sync_hunt.sv
module usbrx_sync_hunt import usbrx_pkg::*; #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp,
  input  logic dm,
  input  logic busy,
  output logic lock
);
  localparam int CONF_AT = OVS + OVS / 2 - 1;
  localparam int CW      = $clog2(CONF_AT + 1);

  hunt_state_t     state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= HS_WAIT_IDLE;
      cnt   <= '0;
      lock  <= 1'b0;
    end else begin
      lock <= 1'b0;
      if (busy) begin
        state <= HS_WAIT_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          HS_WAIT_IDLE: if (line_is_j(dp, dm)) state <= HS_HUNT_EDGE;
          HS_HUNT_EDGE: if (line_is_k(dp, dm)) begin
            state <= HS_CONFIRM;
            cnt   <= '0;
          end
          HS_CONFIRM: begin
            if (cnt == CW'(CONF_AT)) begin
              if (line_is_k(dp, dm)) begin
                lock  <= 1'b1;
                state <= HS_WAIT_IDLE;
              end else begin
                state <= HS_HUNT_EDGE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= HS_WAIT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usbrx_bit_engine.sv
module usbrx_bit_engine import usbrx_pkg::*; #(
  parameter int OVS       = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp,
  input  logic              dm,
  input  logic              lock,
  input  logic              abort,
  output logic              active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data,
  output logic              line_end
);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int PW = $clog2(BYTE_W);

  logic [TW-1:0]     timer, timer_nx;
  logic              prev_lvl;
  logic [OW-1:0]     ones;
  logic [PW-1:0]     bitpos;
  logic [BYTE_W-1:0] shreg;

  logic sample, se0_hit, stuffed, bitv;

  generate
    if ((OVS & (OVS - 1)) == 0) begin : g_wrap_pow2
      assign timer_nx = timer + 1'b1;
    end else begin : g_wrap_cmp
      assign timer_nx = (timer == TW'(OVS - 1)) ? '0 : timer + 1'b1;
    end
  endgenerate

  assign sample  = active && (timer == TW'(OVS - 1));
  assign se0_hit = sample && line_is_se0(dp, dm) && (bitpos != '0);
  assign stuffed = (ones == OW'(STUFF_RUN));
  assign bitv    = (dm == prev_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      timer     <= '0;
      prev_lvl  <= 1'b0;
      ones      <= '0;
      bitpos    <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_data <= '0;
      line_end  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      line_end  <= 1'b0;
      if (lock) begin
        active   <= 1'b1;
        timer    <= TW'(1);
        prev_lvl <= 1'b0;
        ones     <= '0;
        bitpos   <= '0;
      end else if (active) begin
        if (abort) begin
          active <= 1'b0;
        end else begin
          timer <= timer_nx;
          if (se0_hit) begin
            active   <= 1'b0;
            line_end <= 1'b1;
          end else if (sample) begin
            prev_lvl <= dm;
            if (stuffed) begin
              ones <= '0;
            end else begin
              ones   <= bitv ? ones + 1'b1 : '0;
              shreg  <= {bitv, shreg[BYTE_W-1:1]};
              bitpos <= bitpos + 1'b1;
              if (bitpos == PW'(BYTE_W - 1)) begin
                byte_done <= 1'b1;
                byte_data <= {bitv, shreg[BYTE_W-1:1]};
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/usbrx_frame_ctl.sv
module usbrx_frame_ctl import usbrx_pkg::*; #(
  parameter int BUF_BYTES = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              line_end,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              pkt_end,
  output logic [CNT_W-1:0]  pkt_bytes,
  output logic              overflow,
  output logic              abort
);
  logic [CNT_W-1:0] remaining;

  assign abort = byte_done && (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      pkt_end   <= 1'b0;
      pkt_bytes <= '0;
      overflow  <= 1'b0;
    end else begin
      pkt_end  <= 1'b0;
      overflow <= 1'b0;
      if (lock) remaining <= CNT_W'(BUF_BYTES);
      if (byte_done && !abort) begin
        remaining <= remaining - 1'b1;
        out_valid <= 1'b1;
        out_data  <= byte_data;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (abort) overflow <= 1'b1;
      if (line_end) begin
        pkt_end   <= 1'b1;
        pkt_bytes <= CNT_W'(BUF_BYTES) - remaining;
      end
    end
  end
endmodule

// File: rtl/usbrx_ls_rx.sv
module usbrx_ls_rx import usbrx_pkg::*; #(
  parameter int OVS       = 8,
  parameter int BUF_BYTES = 8,
  parameter int STUFF_RUN = 6,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp,
  input  logic             dm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             pkt_end,
  output logic [CNT_W-1:0] pkt_bytes,
  output logic             overflow
);
  logic              lock, active, byte_done, line_end, abort;
  logic [BYTE_W-1:0] byte_data;

  usbrx_sync_hunt #(.OVS(OVS)) u_hunt (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
    .busy(active), .lock(lock)
  );

  usbrx_bit_engine #(.OVS(OVS), .STUFF_RUN(STUFF_RUN)) u_bits (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
    .lock(lock), .abort(abort), .active(active),
    .byte_done(byte_done), .byte_data(byte_data), .line_end(line_end)
  );

  usbrx_frame_ctl #(.BUF_BYTES(BUF_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .byte_done(byte_done), .byte_data(byte_data), .line_end(line_end),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .pkt_end(pkt_end), .pkt_bytes(pkt_bytes), .overflow(overflow),
    .abort(abort)
  );
endmodule

// File: rtl/usbrx_ls_rx_chk.sv
module usbrx_ls_rx_chk #(
  parameter int BUF_BYTES = 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             pkt_end,
  input logic [CNT_W-1:0] pkt_bytes,
  input logic             overflow
);
  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  // R5
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);

  // R5
  end_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> pkt_bytes <= CNT_W'(BUF_BYTES));

  // R7
  ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_end, overflow}));

  // R7
  ovf_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $stable(out_data));

  // R7
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !overflow);
endmodule

bind usbrx_ls_rx usbrx_ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/tb_usbrx_ls_rx.sv
module tb_usbrx_ls_rx;
  localparam int OVS  = 8;
  localparam int BUFN = 8;
  localparam int CW   = $clog2(BUFN + 1);
  localparam logic [1:0] SJ = 2'b01, SK = 2'b10, S0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1, out_ready = 1'b1;
  logic out_valid, pkt_end, overflow;
  logic [7:0] out_data;
  logic [CW-1:0] pkt_bytes;

  usbrx_ls_rx #(.OVS(OVS), .BUF_BYTES(BUFN)) dut (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .pkt_end(pkt_end),
    .pkt_bytes(pkt_bytes), .overflow(overflow));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [1:0] line_q[$];
  logic [7:0] got[$];
  int ends = 0, end_cnt = 0, ovfs = 0;
  int ready_mode = 0;
  int pc = 0;
  bit armed = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) got.push_back(out_data);
    if (pkt_end) begin ends++; end_cnt = int'(pkt_bytes); end
    if (overflow) ovfs++;
  end

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      2: out_ready = 1'b0;
      default: begin
        if (!armed && out_valid) begin armed = 1'b1; pc = 0; end
        else if (armed) pc++;
        out_ready = armed && (pc % 64 == 63);
      end
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input int n);
    repeat (n) line_q.push_back(s);
  endtask

  logic [1:0] cur;
  int ones;
  task automatic emit(input bit b);
    if (b) begin
      line_q.push_back(cur); ones++;
      if (ones == 6) begin cur = (cur == SJ) ? SK : SJ; line_q.push_back(cur); ones = 0; end
    end else begin
      cur = (cur == SJ) ? SK : SJ; line_q.push_back(cur); ones = 0;
    end
  endtask

  task automatic build(input logic [7:0] d[$], input int dribble, input int pre_j, input bit glitch);
    int first_idx[$];
    line_q.delete();
    put(SJ, pre_j);
    put(SK, 1); put(SJ, 1); put(SK, 1); put(SJ, 1);
    put(SK, 1); put(SJ, 1); put(SK, 2);
    cur = SK; ones = 0;
    foreach (d[i]) begin
      first_idx.push_back(line_q.size());
      for (int b = 0; b < 8; b++) emit(d[i][b]);
    end
    for (int i = 0; i < dribble; i++) emit(1'($urandom % 2));
    if (glitch) begin
      for (int i = 1; i < first_idx.size(); i++)
        if (line_q[first_idx[i]] == SK) begin line_q[first_idx[i]] = S0; break; end
    end
    put(S0, 2); put(SJ, 3);
  endtask

  task automatic drive(input int phase);
    @(posedge clk); #2;
    {dp, dm} = SJ;
    repeat (phase) begin @(posedge clk); #2; end
    foreach (line_q[i]) begin
      {dp, dm} = line_q[i];
      repeat (OVS) begin @(posedge clk); #2; end
    end
    repeat (4 * OVS) @(posedge clk);
  endtask

  task automatic check_pkt(input logic [7:0] d[$], input string tag);
    int n = d.size();
    int en = (n > BUFN) ? BUFN : n;
    chk(got.size() == en, tag, got.size(), en);
    for (int i = 0; i < en && i < got.size(); i++)
      chk(got[i] == d[i], tag, got[i], d[i]);
    if (n > BUFN) begin
      chk(ovfs == 1, "R7", ovfs, 1);
      chk(ends == 0, "R7", ends, 0);
    end else begin
      chk(ends == 1, "R5", ends, 1);
      chk(end_cnt == n, "R5", end_cnt, n);
      chk(ovfs == 0, "R5", ovfs, 0);
    end
  endtask

  task automatic clear_mon();
    got.delete(); ends = 0; end_cnt = 0; ovfs = 0;
  endtask

  task automatic run(input logic [7:0] d[$], input int dribble, input bit glitch, input string tag);
    clear_mon();
    build(d, dribble, 2 + $urandom % 4, glitch);
    drive($urandom % 8);
    check_pkt(d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    void'($urandom(32'h5EED_0042));
    // R8 reset state
    {dp, dm} = SK;
    repeat (4) @(posedge clk);
    #2 chk(!out_valid && !pkt_end && !overflow, "R8", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !pkt_end && !overflow, "R8", out_valid, 0);

    // R2: line held at K from reset, never J: no lock
    repeat (5 * OVS) @(posedge clk);
    chk(got.size() == 0 && ends == 0, "R2", got.size(), 0);

    // R1 fixed pattern
    d = '{8'h12, 8'h34, 8'hC5};
    run(d, 0, 1'b0, "R1");

    // R2 stray single K before a packet
    clear_mon();
    line_q.delete();
    d = '{8'hA7, 8'h3C};
    begin
      logic [1:0] keep[$];
      build(d, 0, 2, 1'b0);
      keep = line_q;
      line_q.delete();
      put(SJ, 3); put(SK, 1); put(SJ, 3);
      foreach (keep[i]) line_q.push_back(keep[i]);
    end
    drive(3);
    check_pkt(d, "R2");

    // R3 stuffing-heavy data
    d = '{8'hFF, 8'hFF, 8'h7F, 8'hFE};
    run(d, 0, 1'b0, "R3");

    // R5 partial-byte dribble dropped
    d = '{8'h5A, 8'h0F};
    run(d, 3, 1'b0, "R5");

    // R6 SE0 at slot 0 inside the packet
    d = '{8'h12, 8'h34, 8'h56, 8'h78};
    run(d, 0, 1'b1, "R6");

    // R7 overflow, then a normal packet
    d.delete();
    for (int i = 0; i < BUFN + 1; i++) d.push_back(8'($urandom));
    run(d, 0, 1'b0, "R7");
    d = '{8'h99};
    run(d, 0, 1'b0, "R7");

    // R4 unaccepted byte replaced by later one
    ready_mode = 2;
    d = '{8'hA1, 8'h5C, 8'h3E};
    clear_mon();
    build(d, 0, 3, 1'b0);
    drive(1);
    chk(out_valid == 1'b1, "R4", out_valid, 1);
    chk(out_data == 8'h3E, "R4", out_data, 8'h3E);
    chk(ends == 1 && end_cnt == 3, "R5", end_cnt, 3);
    ready_mode = 0;
    repeat (3) @(posedge clk);
    chk(got.size() == 1, "R4", got.size(), 1);
    if (got.size() > 0) chk(got[0] == 8'h3E, "R4", got[0], 8'h3E);
    @(negedge clk);
    chk(!out_valid, "R4", out_valid, 0);

    // R4 acceptance in the same cycle a new byte lands
    armed = 1'b0; ready_mode = 3;
    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    clear_mon();
    build(d, 0, 3, 1'b0);
    drive(2);
    repeat (70) @(posedge clk);
    chk(got.size() == 4, "R4", got.size(), 4);
    ready_mode = 0;
    repeat (4) @(posedge clk);

    // random packets, mixed back-pressure (R1 R3 R5)
    for (int p = 0; p < 30; p++) begin
      int n = 1 + $urandom % BUFN;
      d.delete();
      for (int i = 0; i < n; i++) d.push_back(8'($urandom));
      ready_mode = (p % 3 == 0) ? 1 : 0;
      run(d, $urandom % 4, 1'b0, "R1");
    end
    ready_mode = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule